// File: doc/BRIEF.md
# Breakpoint Control Register Access Gate

This block decides what happens when software tries to read or write one of the breakpoint control registers. A request carries the breakpoint index, the exception level it comes from (0 to 3), a read/write flag and, for writes, the data. Static configuration inputs describe the higher levels: whether EL3 exists and runs in 32-bit mode, whether EL3 asks for undefined behaviour and gives that check priority, the EL3 debug-trap bit, whether EL2 is enabled and runs in 32-bit mode, its two debug-trap bits, the OS lock, whether halting is allowed, and the external debugger's trap bit.

The block resolves a fixed priority chain into one of six outcomes: undefined instruction, trap to EL2, hypervisor trap, trap to EL3, debug halt, or perform. The outcome, the syndrome class, and for a performed read the register contents are registered and appear one cycle after the request. A performed write loads the selected breakpoint control register inside the block, keeping only the defined fields. Taking the exception is left to the surrounding logic.

Top module: `bkpt_ctl_access_gate`

## Requirements
- R1: A request whose index is at or above NUM_BKPT (default 6) gets the undefined outcome, before any other check.
- R2: A request from exception level 0 gets the undefined outcome.
- R3: From EL1 the checks run in this order: undefined when EL3 exists in 64-bit mode with undefined priority and its trap bit set; trap to EL2 when EL2 is enabled in 64-bit mode with either trap bit set; hypervisor trap when EL2 is enabled in 32-bit mode with either trap bit set; then the EL3 trap check (R4); then the halt check (R5).
- R4: The EL3 trap check fires when EL3 exists in 64-bit mode with its trap bit set; its outcome is undefined when EL3 requests undefined behaviour, otherwise trap to EL3.
- R5: When no earlier check fired, the outcome is debug halt if the OS lock is clear, halting is allowed and the external trap bit is set; otherwise the access is performed.
- R6: From EL2 the EL2 checks are skipped; only the EL3 priority-undefined check, the EL3 trap check and the halt check apply, in that order.
- R7: From EL3 only the halt check applies.
- R8: resp_syndrome is 0x05 with any of the three trap outcomes and 0 otherwise.
- R9: resp_kind is one-hot with resp_valid one cycle after each request and all-zero when no request was made; bit 0 perform, 1 undefined, 2 trap to EL2, 3 hypervisor trap, 4 trap to EL3, 5 debug halt.
- R10: A performed write loads the data ANDed with 0x00FFE1E7 into the selected register; a write with any other outcome leaves every register unchanged.
- R11: A performed read returns the selected register on resp_rdata; resp_rdata is zero in every other cycle.
- R12: After reset all registers read zero and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pulse, one per cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_el | input | 2 | Exception level of the requester |
| req_idx | input | IDX_W | Breakpoint index |
| req_wdata | input | DATA_W | Write data |
| el3_present | input | 1 | EL3 implemented |
| el3_is32 | input | 1 | EL3 runs in 32-bit mode |
| el3_undef_prio | input | 1 | EL3 undefined check has priority |
| el3_undef_req | input | 1 | EL3 requests undefined instead of trap |
| el3_dbg_trap | input | 1 | EL3 debug-access trap bit |
| el2_enabled | input | 1 | EL2 enabled |
| el2_is32 | input | 1 | EL2 runs in 32-bit mode |
| el2_trap_a | input | 1 | First EL2 debug-trap bit |
| el2_trap_b | input | 1 | Second EL2 debug-trap bit |
| os_lock | input | 1 | OS lock set |
| halt_allowed | input | 1 | Halting allowed |
| ext_dbg_trap | input | 1 | External debugger trap-access bit |
| resp_valid | output | 1 | Response present |
| resp_kind | output | 6 | One-hot outcome |
| resp_syndrome | output | 6 | Trap syndrome class |
| resp_rdata | output | DATA_W | Read data of a performed read |

## Verification
The checker watches every cycle for a one-hot outcome with the right latency, the syndrome matching the trap bits, undefined for out-of-range indices and EL0, EL2 never yielding an EL2 trap, EL3 yielding only halt or perform, and read data that is zero outside performed reads and never carries reserved bits. The full ordering of the EL1 and EL2 priority chains, and whether a denied write truly left storage untouched, only show in the bench's sweep over every configuration, level and read/write against a reference model of the registers.

// File: rtl/bkpt_gate_pkg.sv
package bkpt_gate_pkg;
  localparam int KIND_W   = 6;
  localparam int K_DO     = 0;
  localparam int K_UNDEF  = 1;
  localparam int K_TRAP2  = 2;
  localparam int K_HYP    = 3;
  localparam int K_TRAP3  = 4;
  localparam int K_HALT   = 5;
  localparam int SYN_W    = 6;
  localparam logic [SYN_W-1:0] TRAP_CLASS = 6'h05;

  typedef struct packed {
    logic el3_present;
    logic el3_is32;
    logic el3_undef_prio;
    logic el3_undef_req;
    logic el3_dbg_trap;
    logic el2_enabled;
    logic el2_is32;
    logic el2_trap_a;
    logic el2_trap_b;
    logic os_lock;
    logic halt_allowed;
    logic ext_dbg_trap;
  } gate_cfg_t;
endpackage

// File: rtl/bkpt_access_decider.sv
module bkpt_access_decider
  import bkpt_gate_pkg::*;
(
  input  gate_cfg_t         cfg,
  input  logic [1:0]        el,
  input  logic              idx_ok,
  output logic [KIND_W-1:0] kind
);
  logic el3_wide, el3_prio_undef, el3_trap, el2_hit, halt_hit, low_el;

  always_comb begin
    el3_wide       = cfg.el3_present & ~cfg.el3_is32;
    el3_prio_undef = el3_wide & cfg.el3_undef_prio & cfg.el3_dbg_trap;
    el3_trap       = el3_wide & cfg.el3_dbg_trap;
    el2_hit        = cfg.el2_enabled & (cfg.el2_trap_a | cfg.el2_trap_b);
    halt_hit       = ~cfg.os_lock & cfg.halt_allowed & cfg.ext_dbg_trap;
    low_el         = (el != 2'd3);
    kind           = '0;
    if (!idx_ok || el == 2'd0)                      kind[K_UNDEF] = 1'b1;
    else if (low_el && el3_prio_undef)              kind[K_UNDEF] = 1'b1;
    else if (el == 2'd1 && el2_hit && !cfg.el2_is32) kind[K_TRAP2] = 1'b1;
    else if (el == 2'd1 && el2_hit && cfg.el2_is32)  kind[K_HYP]   = 1'b1;
    else if (low_el && el3_trap) begin
      if (cfg.el3_undef_req)                        kind[K_UNDEF] = 1'b1;
      else                                          kind[K_TRAP3] = 1'b1;
    end
    else if (halt_hit)                              kind[K_HALT]  = 1'b1;
    else                                            kind[K_DO]    = 1'b1;
  end
endmodule

// File: rtl/bkpt_ctl_regfile.sv
module bkpt_ctl_regfile #(
  parameter int NUM_BKPT = 6,
  parameter int IDX_W    = 4,
  parameter int DATA_W   = 32,
  parameter logic [DATA_W-1:0] WR_MASK = 32'h00FF_E1E7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] mem_q [NUM_BKPT];
  logic [DATA_W-1:0] mem_d [NUM_BKPT];

  always_comb begin
    for (int i = 0; i < NUM_BKPT; i++) begin
      mem_d[i] = mem_q[i];
      if (wr_en && idx == IDX_W'(i)) mem_d[i] = wr_data & WR_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BKPT; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_BKPT; i++) mem_q[i] <= mem_d[i];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_BKPT; i++) begin
      if (idx == IDX_W'(i)) rd_word = mem_q[i];
    end
  end
endmodule

// File: rtl/bkpt_ctl_access_gate.sv
module bkpt_ctl_access_gate
  import bkpt_gate_pkg::*;
#(
  parameter int NUM_BKPT = 6,
  parameter int IDX_W    = 4,
  parameter int DATA_W   = 32,
  parameter logic [DATA_W-1:0] WR_MASK = 32'h00FF_E1E7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_el,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              el3_present,
  input  logic              el3_is32,
  input  logic              el3_undef_prio,
  input  logic              el3_undef_req,
  input  logic              el3_dbg_trap,
  input  logic              el2_enabled,
  input  logic              el2_is32,
  input  logic              el2_trap_a,
  input  logic              el2_trap_b,
  input  logic              os_lock,
  input  logic              halt_allowed,
  input  logic              ext_dbg_trap,
  output logic              resp_valid,
  output logic [KIND_W-1:0] resp_kind,
  output logic [SYN_W-1:0]  resp_syndrome,
  output logic [DATA_W-1:0] resp_rdata
);
  localparam int RST_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[RST_STAGES-1];

  gate_cfg_t         cfg;
  logic              idx_ok;
  logic [KIND_W-1:0] kind;
  logic              do_write, do_read, is_trap;
  logic [DATA_W-1:0] rd_word;

  assign cfg = '{el3_present, el3_is32, el3_undef_prio, el3_undef_req,
                 el3_dbg_trap, el2_enabled, el2_is32, el2_trap_a,
                 el2_trap_b, os_lock, halt_allowed, ext_dbg_trap};
  assign idx_ok = (int'(req_idx) < NUM_BKPT);

  bkpt_access_decider u_decide (
    .cfg    (cfg),
    .el     (req_el),
    .idx_ok (idx_ok),
    .kind   (kind)
  );

  assign do_write = req_valid &  req_write & kind[K_DO];
  assign do_read  = req_valid & ~req_write & kind[K_DO];
  assign is_trap  = kind[K_TRAP2] | kind[K_HYP] | kind[K_TRAP3];

  bkpt_ctl_regfile #(
    .NUM_BKPT (NUM_BKPT),
    .IDX_W    (IDX_W),
    .DATA_W   (DATA_W),
    .WR_MASK  (WR_MASK)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (do_write),
    .idx     (req_idx),
    .wr_data (req_wdata),
    .rd_word (rd_word)
  );

  // response stage: next-state, then register
  logic              valid_d;
  logic [KIND_W-1:0] kind_d;
  logic [SYN_W-1:0]  syn_d;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    valid_d = req_valid;
    kind_d  = req_valid ? kind : '0;
    syn_d   = (req_valid && is_trap) ? TRAP_CLASS : '0;
    rdata_d = do_read ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      resp_valid    <= 1'b0;
      resp_kind     <= '0;
      resp_syndrome <= '0;
      resp_rdata    <= '0;
    end else begin
      resp_valid    <= valid_d;
      resp_kind     <= kind_d;
      resp_syndrome <= syn_d;
      resp_rdata    <= rdata_d;
    end
  end
endmodule

// File: rtl/bkpt_ctl_access_gate_chk.sv
module bkpt_ctl_access_gate_chk
  import bkpt_gate_pkg::*;
#(
  parameter int NUM_BKPT = 6,
  parameter int IDX_W    = 4,
  parameter int DATA_W   = 32,
  parameter logic [DATA_W-1:0] WR_MASK = 32'h00FF_E1E7
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_el,
  input logic [IDX_W-1:0]  req_idx,
  input logic              resp_valid,
  input logic [KIND_W-1:0] resp_kind,
  input logic [SYN_W-1:0]  resp_syndrome,
  input logic [DATA_W-1:0] resp_rdata
);
  logic in_range;
  assign in_range = (int'(req_idx) < NUM_BKPT);

  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    resp_valid |-> $countones(resp_kind) == 1);
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !resp_valid |-> resp_kind == '0);
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid |=> resp_valid);
  assert_range_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && !in_range) |=> resp_kind[K_UNDEF]);
  assert_el0_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_el == 2'd0) |=> resp_kind[K_UNDEF]);
  assert_el2_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_el == 2'd2) |=> !(resp_kind[K_TRAP2] || resp_kind[K_HYP]));
  assert_el3_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_el == 2'd3 && in_range) |=> (resp_kind[K_DO] || resp_kind[K_HALT]));
  assert_syndrome_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (resp_kind[K_TRAP2] || resp_kind[K_HYP] || resp_kind[K_TRAP3])
      == (resp_syndrome == TRAP_CLASS));
  assert_syn_zero_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (resp_syndrome != TRAP_CLASS) |-> resp_syndrome == '0);
  assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (resp_rdata & ~WR_MASK) == '0);
  assert_rdata_write_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_write) |=> resp_rdata == '0);
  assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_valid |=> resp_rdata == '0);
endmodule

bind bkpt_ctl_access_gate bkpt_ctl_access_gate_chk #(
  .NUM_BKPT (NUM_BKPT),
  .IDX_W    (IDX_W),
  .DATA_W   (DATA_W),
  .WR_MASK  (WR_MASK)
) u_chk (
  .clk           (clk),
  .rst_q_n       (rst_q_n),
  .req_valid     (req_valid),
  .req_write     (req_write),
  .req_el        (req_el),
  .req_idx       (req_idx),
  .resp_valid    (resp_valid),
  .resp_kind     (resp_kind),
  .resp_syndrome (resp_syndrome),
  .resp_rdata    (resp_rdata)
);

// File: tb/bkpt_ctl_access_gate_test.sv
module bkpt_ctl_access_gate_test;
  localparam int NB   = 6;
  localparam int IW   = 4;
  localparam int DW   = 32;
  localparam logic [DW-1:0] MASK = 32'h00FF_E1E7;
  localparam time HALF = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [1:0] req_el;
  logic [IW-1:0] req_idx;
  logic [DW-1:0] req_wdata;
  logic el3_present, el3_is32, el3_undef_prio, el3_undef_req, el3_dbg_trap;
  logic el2_enabled, el2_is32, el2_trap_a, el2_trap_b;
  logic os_lock, halt_allowed, ext_dbg_trap;
  logic resp_valid;
  logic [5:0] resp_kind, resp_syndrome;
  logic [DW-1:0] resp_rdata;

  int total = 0;
  int bad   = 0;
  logic [DW-1:0] model [NB];

  always #HALF clk = ~clk;

  bkpt_ctl_access_gate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_el(req_el), .req_idx(req_idx), .req_wdata(req_wdata),
    .el3_present(el3_present), .el3_is32(el3_is32), .el3_undef_prio(el3_undef_prio),
    .el3_undef_req(el3_undef_req), .el3_dbg_trap(el3_dbg_trap),
    .el2_enabled(el2_enabled), .el2_is32(el2_is32), .el2_trap_a(el2_trap_a),
    .el2_trap_b(el2_trap_b), .os_lock(os_lock), .halt_allowed(halt_allowed),
    .ext_dbg_trap(ext_dbg_trap), .resp_valid(resp_valid), .resp_kind(resp_kind),
    .resp_syndrome(resp_syndrome), .resp_rdata(resp_rdata)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [11:0] c);
    {el3_present, el3_is32, el3_undef_prio, el3_undef_req, el3_dbg_trap,
     el2_enabled, el2_is32, el2_trap_a, el2_trap_b,
     os_lock, halt_allowed, ext_dbg_trap} = c;
  endtask

  // reference outcome code: 0 do, 1 undef, 2 trap EL2, 3 hyp, 4 trap EL3, 5 halt
  function automatic int ref_kind(input logic [1:0] el, input int idx);
    bit e3 = el3_present && !el3_is32;
    bit e2 = el2_enabled && (el2_trap_a || el2_trap_b);
    bit hl = !os_lock && halt_allowed && ext_dbg_trap;
    if (idx >= NB) return 1;                              // R1
    case (el)
      2'd0: return 1;                                     // R2
      2'd1: begin                                         // R3
        if (e3 && el3_undef_prio && el3_dbg_trap) return 1;
        if (e2 && !el2_is32) return 2;
        if (e2 && el2_is32) return 3;
        if (e3 && el3_dbg_trap) return el3_undef_req ? 1 : 4;  // R4
        return hl ? 5 : 0;                                // R5
      end
      2'd2: begin                                         // R6
        if (e3 && el3_dbg_trap) return (el3_undef_prio || el3_undef_req) ? 1 : 4;
        return hl ? 5 : 0;
      end
      default: return hl ? 5 : 0;                         // R7
    endcase
  endfunction

  task automatic do_req(input logic wr, input logic [1:0] el, input int idx,
                        input logic [DW-1:0] wd, input string tag);
    int k = ref_kind(el, idx);
    logic [DW-1:0] exp_rd = '0;
    req_valid = 1'b1; req_write = wr; req_el = el;
    req_idx = IW'(idx); req_wdata = wd;
    if (k == 0 && !wr) exp_rd = model[idx];
    if (k == 0 && wr) model[idx] = wd & MASK;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R9 valid"}, DW'(resp_valid), 1);
    check({tag, " R3 kind"}, DW'(resp_kind), DW'(6'b1 << k));
    check({tag, " R8 syndrome"}, DW'(resp_syndrome), (k >= 2 && k <= 4) ? 32'h5 : 32'h0);
    check({tag, " R11 rdata"}, resp_rdata, exp_rd);
  endtask

  initial begin
    #(HALF * 2 * 190000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_el = '0;
    req_idx = '0; req_wdata = '0; set_cfg('0);
    for (int i = 0; i < NB; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    check("R12 valid", DW'(resp_valid), 0);
    check("R12 kind", DW'(resp_kind), 0);
    check("R12 rdata", resp_rdata, 0);
    for (int i = 0; i < NB; i++) do_req(1'b0, 2'd3, i, '0, "R12 readback");

    // R10 mask on a permissive write
    do_req(1'b1, 2'd3, 2, 32'hFFFF_FFFF, "R10 write");
    do_req(1'b0, 2'd3, 2, '0, "R10 read");
    check("R10 masked", resp_rdata, MASK);

    // R1 largest index, fully permissive
    do_req(1'b0, 2'd3, (1 << IW) - 1, '0, "R1 top index");
    do_req(1'b0, 2'd1, NB, '0, "R1 first bad index");

    // sweep every configuration and level
    for (int c = 0; c < 4096; c++) begin
      set_cfg(12'(c));
      for (int el = 0; el < 4; el++) begin
        int idx = (c + el) % 8;
        logic wr = logic'(c[0] ^ el[0]);
        do_req(wr, 2'(el), idx, 32'(c * 32'h9E37_79B1 + el), "sweep");
      end
    end

    // R10 denied writes leave storage as is, R11 read everything back
    set_cfg(12'b1000_1000_0000);   // EL3 64-bit with trap bit: EL1 traps to EL3
    for (int i = 0; i < NB; i++) do_req(1'b1, 2'd1, i, 32'h00AA_A1A5, "R10 denied write");
    set_cfg('0);
    for (int i = 0; i < NB; i++) do_req(1'b0, 2'd1, i, '0, "R10 unchanged read");

    // R9 idle cycle after a request
    @(negedge clk);
    check("R9 idle kind", DW'(resp_kind), 0);
    check("R9 idle valid", DW'(resp_valid), 0);
    check("R11 idle rdata", resp_rdata, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule